// File: doc/BRIEF.md
# Periodic Interval Timer with Held Interrupt

This block is a 16-bit down-counting interval timer that sits on a small 8-bit processor bus. Software writes a reload value as two bytes into a latch, and writing the upper byte starts the count. Each pulse on the count-enable input lowers the counter by one. When the counter passes through zero the block raises a timer flag. If the timer interrupt is enabled, the active-low interrupt output goes low and stays low until software acknowledges the event.

In free-run mode the counter refills itself from the latch after every zero event, so interrupts arrive at a fixed rate set by the latch value, for example once every sixtieth of a second. In one-shot mode only the first zero event after a load raises the flag. After that the counter keeps wrapping downward without refilling. The usual acknowledge is a read of the counter's low byte, which clears the flag in that same bus access. If the acknowledge is missing, the interrupt stays asserted and the processor re-enters its handler again and again.

Top module: `pit_timer`

## Requirements
- R1: A zero event happens on a count-enable pulse that finds the counter at zero, provided the counter is running free or is armed in one-shot mode. A zero event sets the timer flag. After that pulse the counter reads 0xFFFF.
- R2: While the timer flag and the timer enable bit (bit 6 of the enable register, address 6) are both set, `irq_n` is driven low. It stays low for as long as both remain set, regardless of time or count pulses.
- R3: A read of address 0 returns the counter's low byte and clears the timer flag at the clock edge of that access. `irq_n` is high again one cycle later.
- R4: Writes to addresses 0 and 2 set the latch low byte. Writes to address 3 set the latch high byte only. A write to address 1 sets the latch high byte, copies the whole latch into the counter, clears the flag and arms one-shot mode. Addresses 2 and 3 read back the latch low and high bytes.
- R5: Bit 0 of the control register (address 4) set to 1 selects free-run mode. After a load with value N, the first zero event comes N+1 count pulses later. The pulse after a zero event refills the counter from the latch, so later zero events come every N+2 pulses.
- R6: A write to address 6 with bit 7 = 1 sets the enable bits given as 1 in bits 6..0. With bit 7 = 0 it clears them. Reads of address 6 return bit 7 as 1 and bit 6 as the timer enable. While the timer enable is 0, `irq_n` stays high even when the flag is set.
- R7: Address 5 reads the timer flag in bit 6 and, in bit 7, the OR of all enabled set flags. Other bits read 0. Writing 1 to bit 6 of address 5 clears the timer flag.
- R8: In one-shot mode (control bit 0 = 0) only the first zero event after a load sets the flag. After that the counter keeps decrementing and wraps from 0 to 0xFFFF without refilling and without setting the flag again.
- R9: If a zero event and a clearing read of address 0 fall in the same cycle, the flag ends up set.
- R10: After synchronous reset the flag is 0 and the enable bits are 0, so address 6 reads 0x80. The counter and latch hold 0xFFFF, the mode is one-shot and disarmed, and `irq_n` is high.
- R11: Reading address 1 returns the counter's high byte and leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable, one decrement per cycle it is high |
| cs | input | 1 | Chip select for bus accesses |
| rd | input | 1 | Read strobe, qualified by cs |
| wr | input | 1 | Write strobe, qualified by cs |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of a read, zero otherwise |
| irq_n | output | 1 | Active-low interrupt request, released high when idle |

## Verification
A wrong flag shows on `irq_n` and on address 5 in the cycle after the offending edge. A wrong reload or arm state stays hidden until the next time the counter passes zero, which is N+1 or N+2 pulses away. A wrong value in the counter itself shows on the next read of address 0 or 1. The bench therefore places its flag checks one pulse before and one pulse after each expected zero event, so that an event arriving one count early or late is caught. It also holds the interrupt through idle cycles to show that it is a held level and not a pulse. Finally, it drives a full wrap of the counter in one-shot mode to catch a second event that should not occur.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int PIT_DW = 8;
    localparam int PIT_AW = 4;

    // Register addresses
    localparam logic [PIT_AW-1:0] RA_CNT_LO = 4'd0;
    localparam logic [PIT_AW-1:0] RA_CNT_HI = 4'd1;
    localparam logic [PIT_AW-1:0] RA_LAT_LO = 4'd2;
    localparam logic [PIT_AW-1:0] RA_LAT_HI = 4'd3;
    localparam logic [PIT_AW-1:0] RA_CTRL   = 4'd4;
    localparam logic [PIT_AW-1:0] RA_FLAG   = 4'd5;
    localparam logic [PIT_AW-1:0] RA_IEN    = 4'd6;

    // Bit positions inside status/enable bytes
    localparam int BIT_ANY   = 7;
    localparam int BIT_TMR   = 6;
    localparam int BIT_SETCL = 7;
    localparam int BIT_FREE  = 0;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_FREERUN = 1'b1
    } pit_mode_e;

    // Decoded bus strobes, one cycle wide
    typedef struct packed {
        logic wr_lat_lo;
        logic wr_lat_hi;
        logic load;
        logic wr_ctrl;
        logic wr_flag;
        logic wr_ien;
        logic ack_rd;
    } pit_req_t;

    function automatic logic is_addr(input logic [PIT_AW-1:0] a,
                                     input logic [PIT_AW-1:0] ref_a);
        return a == ref_a;
    endfunction

endpackage

// File: rtl/pit_decode.sv
module pit_decode
    import pit_pkg::*;
#(
    parameter int ADDR_W = PIT_AW
) (
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output pit_req_t          req
);

    logic wsel;
    logic rsel;

    assign wsel = cs && wr;
    assign rsel = cs && rd;

    always_comb begin
        req           = '0;
        req.wr_lat_lo = wsel && (is_addr(addr, RA_CNT_LO) || is_addr(addr, RA_LAT_LO));
        req.wr_lat_hi = wsel && (is_addr(addr, RA_CNT_HI) || is_addr(addr, RA_LAT_HI));
        req.load      = wsel && is_addr(addr, RA_CNT_HI);
        req.wr_ctrl   = wsel && is_addr(addr, RA_CTRL);
        req.wr_flag   = wsel && is_addr(addr, RA_FLAG);
        req.wr_ien    = wsel && is_addr(addr, RA_IEN);
        req.ack_rd    = rsel && is_addr(addr, RA_CNT_LO);
    end

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int DATA_W = PIT_DW,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  pit_req_t          req,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  lat,
    output pit_mode_e         mode,
    output logic              armed,
    output logic              reload_pend,
    output logic              zero_evt
);

    logic at_zero;
    logic may_fire;

    assign at_zero  = (cnt == '0);
    assign may_fire = (mode == MODE_FREERUN) || armed;
    assign zero_evt = cnt_en && !req.load && !reload_pend && at_zero && may_fire;

    // Latch halves and mode
    always_ff @(posedge clk) begin
        if (rst) begin
            lat  <= '1;
            mode <= MODE_ONESHOT;
        end else begin
            if (req.wr_lat_lo) lat[DATA_W-1:0]     <= wdata;
            if (req.wr_lat_hi) lat[CNT_W-1:DATA_W] <= wdata;
            if (req.wr_ctrl)   mode <= pit_mode_e'(wdata[BIT_FREE]);
        end
    end

    // Counter, refill and one-shot arm
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '1;
            reload_pend <= 1'b0;
            armed       <= 1'b0;
        end else if (req.load) begin
            cnt         <= {wdata, lat[DATA_W-1:0]};
            reload_pend <= 1'b0;
            armed       <= 1'b1;
        end else if (cnt_en) begin
            if (reload_pend) begin
                cnt         <= lat;
                reload_pend <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
                if (at_zero) begin
                    reload_pend <= (mode == MODE_FREERUN);
                    armed       <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/pit_irq.sv
module pit_irq
    import pit_pkg::*;
#(
    parameter int DATA_W = PIT_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  pit_req_t          req,
    input  logic [DATA_W-1:0] wdata,
    input  logic              zero_evt,
    output logic              flag,
    output logic              ien,
    output logic              irq_n
);

    logic flag_clr;

    assign flag_clr = req.ack_rd || req.load || (req.wr_flag && wdata[BIT_TMR]);

    // A zero event outranks every clearing source in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (zero_evt) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien <= 1'b0;
        end else if (req.wr_ien) begin
            if (wdata[BIT_SETCL]) ien <= ien | wdata[BIT_TMR];
            else                  ien <= ien & ~wdata[BIT_TMR];
        end
    end

    assign irq_n = !(flag && ien);

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int DATA_W = PIT_DW,
    parameter int ADDR_W = PIT_AW,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_n
);

    pit_req_t         req;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lat;
    pit_mode_e        mode;
    logic             armed;
    logic             reload_pend;
    logic             zero_evt;
    logic             tmr_flag;
    logic             tmr_ien;

    pit_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cs   (cs),
        .rd   (rd),
        .wr   (wr),
        .addr (addr),
        .req  (req)
    );

    pit_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .cnt_en      (cnt_en),
        .req         (req),
        .wdata       (wdata),
        .cnt         (cnt),
        .lat         (lat),
        .mode        (mode),
        .armed       (armed),
        .reload_pend (reload_pend),
        .zero_evt    (zero_evt)
    );

    pit_irq #(.DATA_W(DATA_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wdata    (wdata),
        .zero_evt (zero_evt),
        .flag     (tmr_flag),
        .ien      (tmr_ien),
        .irq_n    (irq_n)
    );

    // Read multiplexer
    always_comb begin
        rdata = '0;
        if (cs && rd) begin
            case (addr)
                RA_CNT_LO: rdata = cnt[DATA_W-1:0];
                RA_CNT_HI: rdata = cnt[CNT_W-1:DATA_W];
                RA_LAT_LO: rdata = lat[DATA_W-1:0];
                RA_LAT_HI: rdata = lat[CNT_W-1:DATA_W];
                RA_CTRL:   rdata[BIT_FREE] = (mode == MODE_FREERUN);
                RA_FLAG: begin
                    rdata[BIT_ANY] = tmr_flag && tmr_ien;
                    rdata[BIT_TMR] = tmr_flag;
                end
                RA_IEN: begin
                    rdata[BIT_SETCL] = 1'b1;
                    rdata[BIT_TMR]   = tmr_ien;
                end
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
    import pit_pkg::*;
#(
    parameter int DATA_W = PIT_DW,
    parameter int ADDR_W = PIT_AW,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              cnt_en,
    input logic              cs,
    input logic              rd,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic              irq_n,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  lat,
    input logic              freerun,
    input logic              armed,
    input logic              reload_pend,
    input logic              zero_evt,
    input logic              flag,
    input logic              ien
);

    logic ack_rd;
    logic load_wr;

    assign ack_rd  = cs && rd && (addr == RA_CNT_LO);
    assign load_wr = cs && wr && (addr == RA_CNT_HI);

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        zero_evt |=> flag); // R1

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !cs) |=> !irq_n); // R2

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && ack_rd && !zero_evt) |=> irq_n); // R3

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        load_wr |=> (cnt == lat)); // R4

    AST_REFILL: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && reload_pend && !load_wr) |=> (cnt == $past(lat))); // R5

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ien |-> irq_n); // R6

    AST_ONESHOT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (!freerun && !armed) |-> !zero_evt); // R8

    AST_EVT_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
        (zero_evt && ack_rd) |=> flag); // R9

endmodule

bind pit_timer pit_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_en      (cnt_en),
    .cs          (cs),
    .rd          (rd),
    .wr          (wr),
    .addr        (addr),
    .irq_n       (irq_n),
    .cnt         (cnt),
    .lat         (lat),
    .freerun     (mode == pit_pkg::MODE_FREERUN),
    .armed       (armed),
    .reload_pend (reload_pend),
    .zero_evt    (zero_evt),
    .flag        (tmr_flag),
    .ien         (tmr_ien)
);

// File: tb/tb_pit_timer.sv
module tb_pit_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       cs = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit       is_irq;
        logic [7:0] exp;
        string    req;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     smp;

    always #2.5 clk = ~clk;

    pit_timer dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cs(cs), .rd(rd), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
    );

    // Monitor: compares each queued expectation against the ports
    initial begin
        forever begin
            @(smp);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {7'b0, irq_n} : rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%02h expected=%02h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; wr = 0;
    endtask

    task automatic chk_rd(input logic [3:0] a, input logic [7:0] e,
                          input string r, input bit with_cnt = 0);
        @(negedge clk);
        cs = 1; rd = 1; addr = a; cnt_en = with_cnt;
        #1;
        sb_q.push_back('{is_irq: 1'b0, exp: e, req: r});
        -> smp;
        @(negedge clk);
        cs = 0; rd = 0; cnt_en = 0;
    endtask

    task automatic chk_irq(input logic e, input string r);
        sb_q.push_back('{is_irq: 1'b1, exp: {7'b0, e}, req: r});
        -> smp;
        #1;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_en = 1;
            @(negedge clk); cnt_en = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // Reset state
        chk_irq(1'b1, "R10 irq idle");
        chk_rd(4'd5, 8'h00, "R10 flag reg");
        chk_rd(4'd6, 8'h80, "R10 enable reg");
        chk_rd(4'd0, 8'hFF, "R10 counter low");

        // Free-run, N=3, enabled
        bus_wr(4'd4, 8'h01);
        bus_wr(4'd6, 8'hC0);
        chk_rd(4'd6, 8'hC0, "R6 enable set");
        bus_wr(4'd0, 8'h03);
        bus_wr(4'd1, 8'h00);
        chk_rd(4'd0, 8'h03, "R4 load copies latch");
        pulse(3);
        chk_rd(4'd5, 8'h00, "R5 no event at N counts");
        chk_irq(1'b1, "R5 irq high before event");
        pulse(1);
        chk_irq(1'b0, "R2 irq low on event");
        chk_rd(4'd5, 8'hC0, "R1 R7 flag set and any");
        repeat (6) @(negedge clk);
        chk_irq(1'b0, "R2 irq held while idle");
        chk_rd(4'd1, 8'hFF, "R11 counter high after zero");
        chk_irq(1'b0, "R11 high read keeps irq");
        chk_rd(4'd0, 8'hFF, "R3 ack read value");
        chk_irq(1'b1, "R3 irq released");
        chk_rd(4'd5, 8'h00, "R3 flag cleared");

        // Periodic refill: next event after N+2 pulses
        pulse(1);
        chk_rd(4'd0, 8'h03, "R5 refill from latch");
        pulse(3);
        chk_rd(4'd5, 8'h00, "R5 no event before N+2");
        pulse(1);
        chk_rd(4'd5, 8'hC0, "R5 periodic event");

        // Collision: flag still set, zero event and ack read together
        pulse(4);
        chk_rd(4'd0, 8'h00, "R9 collision read value", 1'b1);
        chk_rd(4'd5, 8'hC0, "R9 event wins over ack");

        // Clear through flag register
        bus_wr(4'd5, 8'h40);
        chk_irq(1'b1, "R7 flag write releases irq");
        chk_rd(4'd5, 8'h00, "R7 flag write clears");

        // Masked interrupt
        bus_wr(4'd6, 8'h40);
        chk_rd(4'd6, 8'h80, "R6 enable cleared");
        bus_wr(4'd1, 8'h00);
        pulse(4);
        chk_irq(1'b1, "R6 masked irq stays high");
        chk_rd(4'd5, 8'h40, "R6 flag without any bit");

        // One-shot
        bus_wr(4'd4, 8'h00);
        bus_wr(4'd1, 8'h00);
        chk_rd(4'd5, 8'h00, "R4 load clears flag");
        bus_wr(4'd6, 8'hC0);
        pulse(4);
        chk_irq(1'b0, "R8 one-shot first event");
        bus_wr(4'd5, 8'h40);
        pulse(1);
        chk_rd(4'd0, 8'hFE, "R8 no refill in one-shot");
        @(negedge clk); cnt_en = 1;
        repeat (65540) @(negedge clk);
        cnt_en = 0;
        chk_rd(4'd5, 8'h00, "R8 no second event after wrap");
        chk_irq(1'b1, "R8 irq stays high after wrap");
        chk_rd(4'd0, 8'hFA, "R8 counter wrapped");

        // Latch readback, high write without load
        bus_wr(4'd2, 8'h5A);
        bus_wr(4'd3, 8'hA5);
        chk_rd(4'd2, 8'h5A, "R4 latch low readback");
        chk_rd(4'd3, 8'hA5, "R4 latch high readback");
        chk_rd(4'd1, 8'hFF, "R4 high latch write does not load");
        chk_rd(4'd4, 8'h00, "R5 mode readback one-shot");

        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule